// File: doc/BRIEF.md
# Link Equalization Training Controller

This block is the receive-side sequencer that trains a serial link's equalization with its link partner. One of four recovery causes starts a run: power-up, a hard reset request, loss of symbol sync, or a hot-plug timeout. The controller waits for alignment with the partner, then sends a setup exchange message and a rate-change message that names the partner's starting coefficient preset. Each message goes out on a valid/ack request bus.

At the higher rate it first runs measurement windows until a coarse error-ratio flag is met. It then runs fine evaluation windows under a programmable cycle budget. A failed window sends the partner one coefficient request, chosen by a hint from the local adaptation logic. After the partner acknowledges, the controller strobes local receiver equalizer tuning and waits for it to finish before it measures again. A passing window moves it to the role-reversal phase, where the partner trains the local transmitter. If the budget runs out, or sync is lost at the higher rate, the controller drops to the lower rate. It then either restarts recovery or parks in a failed state.

Top module: `eqtrain_top`

## Requirements
- R1: After reset, reqValid, rateHigh, busy, trained and failed are all 0.
- R2: When idle, trained or failed, a pulse on any of trigPowerUp, trigHardReset, trigSyncLoss or trigHotPlug sets busy to 1 and rateHigh to 0. No request is issued until alignDone is 1. The controller then sends a setup message (reqKind 0, reqCode 0), followed by a rate-change message (reqKind 1, reqCode 3 = preset) whose reqPreset is startPreset clamped to 10.
- R3: While reqValid is 1 and reqAck is 0, reqValid, reqKind, reqCode and reqPreset hold steady. A message is retired only by reqAck.
- R4: The acknowledge of the rate-change message sets rateHigh to 1 and loads budget. Coarse windows of WIN_LEN cycles repeat, with no request, until coarseOk is 1 at a window's last cycle.
- R5: When berOk is 1 at the last cycle of an evaluation window, the controller issues no further requests. It stays busy until peerDone, then shows trained=1, busy=0 and rateHigh=1.
- R6: A failed evaluation window with budget left issues exactly one coefficient message (reqKind 2). Its reqCode equals adjHint (0 hold, 1 increment, 2 decrement, 3 preset). Its reqPreset is hintPreset clamped to 10 for code 3, and 0 otherwise.
- R7: The acknowledge of a coefficient message gives a one-cycle tuneStart pulse in the next cycle. No request follows until tuneDone is seen.
- R8: The budget counts down in every high-rate cycle before role reversal. When it reaches zero, rateHigh drops. If expiry falls in the same cycle as a passing evaluation verdict, the pass wins.
- R9: trigSyncLoss while rateHigh is 1 drops rateHigh in the next cycle.
- R10: After a drop to the low rate, retryEn=1 restarts recovery (busy stays 1). retryEn=0 parks the controller with failed=1 and busy=0 until a trigger arrives.
- R11: berOk and coarseOk are only sampled in a window's last cycle. A pulse earlier in the window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigPowerUp | input | 1 | Recovery cause: power-up |
| trigHardReset | input | 1 | Recovery cause: hard reset request |
| trigSyncLoss | input | 1 | Recovery cause and fallback cause: sync lost |
| trigHotPlug | input | 1 | Recovery cause: hot-plug timeout |
| alignDone | input | 1 | Partner alignment handshake complete |
| startPreset | input | 4 | Partner starting preset for the rate change |
| budget | input | BUDGET_W | Training budget in cycles |
| coarseOk | input | 1 | Coarse error-ratio target met (window end) |
| berOk | input | 1 | Target error ratio met (window end) |
| adjHint | input | 2 | Requested coefficient action |
| hintPreset | input | 4 | Preset index for a preset action |
| tuneDone | input | 1 | Local equalizer tuning finished |
| peerDone | input | 1 | Partner finished role-reversal training |
| retryEn | input | 1 | Restart recovery after fallback |
| reqAck | input | 1 | Partner accepted the request |
| reqValid | output | 1 | Request present |
| reqKind | output | 2 | 0 setup, 1 rate change, 2 coefficient |
| reqCode | output | 2 | 0 hold, 1 inc, 2 dec, 3 preset |
| reqPreset | output | 4 | Preset index 0..10 |
| tuneStart | output | 1 | Start local equalizer tuning |
| rateHigh | output | 1 | Link at the higher rate |
| busy | output | 1 | Training in progress |
| trained | output | 1 | Training succeeded |
| failed | output | 1 | Training failed, parked |

## Verification
The budget expiry and the final evaluation verdict can land in the same cycle. The bench forces this by programming a budget of two windows less one cycle, so that the zero count lines up with the last cycle of the first fine window. It then expects trained rather than a fallback. A budget one cycle shorter must expire inside that window and end in the failed state, which shows the tie-break applies only to the exact coincidence.

// File: rtl/eqtrain_pkg.sv
package eqtrain_pkg;

  typedef enum logic [1:0] {
    ADJ_HOLD   = 2'd0,
    ADJ_INC    = 2'd1,
    ADJ_DEC    = 2'd2,
    ADJ_PRESET = 2'd3
  } adj_t;

  typedef enum logic [1:0] {
    MSG_SETUP = 2'd0,
    MSG_SPEED = 2'd1,
    MSG_COEF  = 2'd2
  } msg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ALIGN, S_SETUP, S_SPEED, S_LINK, S_EVAL,
    S_COEF, S_TUNE, S_REVERSE, S_FALLBACK, S_DONE, S_FAILED
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBudget;
    logic runBudget;
    logic runWindow;
    logic latchStart;
    logic latchCoef;
    logic tuneKick;
  } dp_ctrl_t;

  localparam logic [3:0] PRESET_TOP = 4'd10;

  function automatic logic [3:0] clampPreset(input logic [3:0] p);
    return (p > PRESET_TOP) ? PRESET_TOP : p;
  endfunction

endpackage

// File: rtl/eqtrain_dp.sv
module eqtrain_dp
  import eqtrain_pkg::*;
#(
  parameter int BUDGET_W = 16,
  parameter int WIN_LEN  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctrl_t            ctl,
  input  logic [BUDGET_W-1:0] budget,
  input  logic [3:0]          startPreset,
  input  logic [1:0]          adjHint,
  input  logic [3:0]          hintPreset,
  output logic                winEnd,
  output logic                budExpired,
  output logic [1:0]          coefCode,
  output logic [3:0]          coefPreset,
  output logic                tuneStart
);

  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  logic [BUDGET_W-1:0] budCnt;
  logic [WIN_W-1:0]    winCnt;

  assign winEnd     = ctl.runWindow && (winCnt == WIN_LAST);
  assign budExpired = ctl.runBudget && (budCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      budCnt <= '0;
    end else if (ctl.loadBudget) begin
      budCnt <= budget;
    end else if (ctl.runBudget && budCnt != '0) begin
      budCnt <= budCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (!ctl.runWindow || winEnd) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefCode   <= ADJ_HOLD;
      coefPreset <= '0;
    end else if (ctl.latchStart) begin
      coefCode   <= ADJ_PRESET;
      coefPreset <= clampPreset(startPreset);
    end else if (ctl.latchCoef) begin
      coefCode   <= adjHint;
      coefPreset <= (adjHint == ADJ_PRESET) ? clampPreset(hintPreset) : 4'd0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tuneStart <= 1'b0;
    else       tuneStart <= ctl.tuneKick;
  end

  // R4: a budget load takes the programmed value
  p_budget_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadBudget |=> budCnt == $past(budget));

  // R6: a stored preset index never leaves the legal range
  p_preset_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    coefPreset <= PRESET_TOP);

  // R7: tuning strobe lasts a single cycle
  p_tune_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    tuneStart |=> !tuneStart);

endmodule

// File: rtl/eqtrain_ctrl.sv
module eqtrain_ctrl
  import eqtrain_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyTrig,
  input  logic       syncLoss,
  input  logic       alignDone,
  input  logic       coarseOk,
  input  logic       berOk,
  input  logic       tuneDone,
  input  logic       peerDone,
  input  logic       retryEn,
  input  logic       reqAck,
  input  logic       winEnd,
  input  logic       budExpired,
  input  logic [1:0] coefCode,
  input  logic [3:0] coefPreset,
  output dp_ctrl_t   ctl,
  output logic       reqValid,
  output logic [1:0] reqKind,
  output logic [1:0] reqCode,
  output logic [3:0] reqPreset,
  output logic       rateHigh,
  output logic       busy,
  output logic       trained,
  output logic       failed
);

  phase_t state, nxt;
  logic   highRate;

  assign highRate = state inside {S_LINK, S_EVAL, S_COEF, S_TUNE, S_REVERSE};

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.runBudget = state inside {S_LINK, S_EVAL, S_COEF, S_TUNE};
    ctl.runWindow = state inside {S_LINK, S_EVAL};
    if (highRate && syncLoss) begin
      nxt = S_FALLBACK;
    end else begin
      unique case (state)
        S_IDLE, S_DONE, S_FAILED: if (anyTrig) nxt = S_ALIGN;
        S_ALIGN: if (alignDone) nxt = S_SETUP;
        S_SETUP: if (reqAck) begin
          nxt = S_SPEED;
          ctl.latchStart = 1'b1;
        end
        S_SPEED: if (reqAck) begin
          nxt = S_LINK;
          ctl.loadBudget = 1'b1;
        end
        S_LINK: begin
          if (budExpired)                nxt = S_FALLBACK;
          else if (winEnd && coarseOk)   nxt = S_EVAL;
        end
        S_EVAL: begin
          if (winEnd && berOk)           nxt = S_REVERSE;
          else if (budExpired)           nxt = S_FALLBACK;
          else if (winEnd) begin
            nxt = S_COEF;
            ctl.latchCoef = 1'b1;
          end
        end
        S_COEF: begin
          if (budExpired)                nxt = S_FALLBACK;
          else if (reqAck) begin
            nxt = S_TUNE;
            ctl.tuneKick = 1'b1;
          end
        end
        S_TUNE: begin
          if (budExpired)                nxt = S_FALLBACK;
          else if (tuneDone)             nxt = S_EVAL;
        end
        S_REVERSE: if (peerDone) nxt = S_DONE;
        S_FALLBACK: nxt = retryEn ? S_ALIGN : S_FAILED;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    reqValid  = 1'b0;
    reqKind   = MSG_SETUP;
    reqCode   = ADJ_HOLD;
    reqPreset = '0;
    unique case (state)
      S_SETUP: reqValid = 1'b1;
      S_SPEED: begin
        reqValid  = 1'b1;
        reqKind   = MSG_SPEED;
        reqCode   = coefCode;
        reqPreset = coefPreset;
      end
      S_COEF: begin
        reqValid  = 1'b1;
        reqKind   = MSG_COEF;
        reqCode   = coefCode;
        reqPreset = coefPreset;
      end
      default: ;
    endcase
  end

  assign rateHigh = highRate || (state == S_DONE);
  assign busy     = !(state inside {S_IDLE, S_DONE, S_FAILED});
  assign trained  = (state == S_DONE);
  assign failed   = (state == S_FAILED);

  // R3: an unacknowledged message stays on the bus unchanged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck && !syncLoss && !budExpired
      |=> reqValid && $stable(reqKind) && $stable(reqCode) && $stable(reqPreset));

  // R8: expiry drops the rate unless a passing verdict coincides
  p_expire_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    budExpired && !(state == S_EVAL && winEnd && berOk) |=> !rateHigh);

  // R9: sync loss at the high rate leaves it
  p_sync_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    rateHigh && syncLoss |=> !rateHigh);

  // R10: success and failure never shown together
  p_status_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(trained && failed));

endmodule

// File: rtl/eqtrain_top.sv
module eqtrain_top
  import eqtrain_pkg::*;
#(
  parameter int BUDGET_W = 16,
  parameter int WIN_LEN  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trigPowerUp,
  input  logic                trigHardReset,
  input  logic                trigSyncLoss,
  input  logic                trigHotPlug,
  input  logic                alignDone,
  input  logic [3:0]          startPreset,
  input  logic [BUDGET_W-1:0] budget,
  input  logic                coarseOk,
  input  logic                berOk,
  input  logic [1:0]          adjHint,
  input  logic [3:0]          hintPreset,
  input  logic                tuneDone,
  input  logic                peerDone,
  input  logic                retryEn,
  input  logic                reqAck,
  output logic                reqValid,
  output logic [1:0]          reqKind,
  output logic [1:0]          reqCode,
  output logic [3:0]          reqPreset,
  output logic                tuneStart,
  output logic                rateHigh,
  output logic                busy,
  output logic                trained,
  output logic                failed
);

  dp_ctrl_t   ctl;
  logic       winEnd;
  logic       budExpired;
  logic [1:0] coefCode;
  logic [3:0] coefPreset;
  logic       anyTrig;

  assign anyTrig = trigPowerUp | trigHardReset | trigSyncLoss | trigHotPlug;

  eqtrain_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .anyTrig(anyTrig), .syncLoss(trigSyncLoss),
    .alignDone(alignDone), .coarseOk(coarseOk), .berOk(berOk),
    .tuneDone(tuneDone), .peerDone(peerDone), .retryEn(retryEn),
    .reqAck(reqAck), .winEnd(winEnd), .budExpired(budExpired),
    .coefCode(coefCode), .coefPreset(coefPreset), .ctl(ctl),
    .reqValid(reqValid), .reqKind(reqKind), .reqCode(reqCode),
    .reqPreset(reqPreset), .rateHigh(rateHigh), .busy(busy),
    .trained(trained), .failed(failed)
  );

  eqtrain_dp #(.BUDGET_W(BUDGET_W), .WIN_LEN(WIN_LEN)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .budget(budget),
    .startPreset(startPreset), .adjHint(adjHint), .hintPreset(hintPreset),
    .winEnd(winEnd), .budExpired(budExpired), .coefCode(coefCode),
    .coefPreset(coefPreset), .tuneStart(tuneStart)
  );

endmodule

// File: tb/test_eqtrain_top.sv
`timescale 1ns/1ps
module test_eqtrain_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPowerUp = 0, trigHardReset = 0, trigSyncLoss = 0, trigHotPlug = 0;
  logic alignDone = 0, coarseOk = 0, berOk = 0, tuneDone = 0, peerDone = 0;
  logic retryEn = 0, reqAck = 0;
  logic [3:0]  startPreset = 4'd5;
  logic [15:0] budget = 16'd1000;
  logic [1:0]  adjHint = 2'd0;
  logic [3:0]  hintPreset = 4'd0;
  logic        reqValid, tuneStart, rateHigh, busy, trained, failed;
  logic [1:0]  reqKind, reqCode;
  logic [3:0]  reqPreset;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  eqtrain_top i_eqtrain_top (
    .clk(clk), .rstN(rstN), .trigPowerUp(trigPowerUp), .trigHardReset(trigHardReset),
    .trigSyncLoss(trigSyncLoss), .trigHotPlug(trigHotPlug), .alignDone(alignDone),
    .startPreset(startPreset), .budget(budget), .coarseOk(coarseOk), .berOk(berOk),
    .adjHint(adjHint), .hintPreset(hintPreset), .tuneDone(tuneDone), .peerDone(peerDone),
    .retryEn(retryEn), .reqAck(reqAck), .reqValid(reqValid), .reqKind(reqKind),
    .reqCode(reqCode), .reqPreset(reqPreset), .tuneStart(tuneStart), .rateHigh(rateHigh),
    .busy(busy), .trained(trained), .failed(failed)
  );

  // hint, hintPreset, expected code, expected preset
  localparam logic [11:0] VEC [6] = '{
    {2'd1, 4'd7,  2'd1, 4'd0},
    {2'd2, 4'd0,  2'd2, 4'd0},
    {2'd0, 4'd3,  2'd0, 4'd0},
    {2'd3, 4'd4,  2'd3, 4'd4},
    {2'd3, 4'd13, 2'd3, 4'd10},
    {2'd3, 4'd15, 2'd3, 4'd10}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitReq(input string tag);
    for (int n = 0; n < 400 && !reqValid; n++) @(negedge clk);
    chk(tag, int'(reqValid), 1);
  endtask

  task automatic ackReq();
    @(negedge clk) reqAck = 1'b1;
    @(negedge clk) reqAck = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic bringUp(input logic [15:0] b);
    alignDone = 1'b1;
    waitReq("R2 setup request");
    chk("R2 setup kind", int'(reqKind), 0);
    repeat (3) @(negedge clk);
    chk("R3 held without ack", int'(reqValid), 1);
    chk("R3 kind held", int'(reqKind), 0);
    ackReq();
    waitReq("R2 rate request");
    chk("R2 rate kind", int'(reqKind), 1);
    chk("R2 rate code", int'(reqCode), 3);
    chk("R2 start preset", int'(reqPreset), int'(startPreset > 4'd10 ? 4'd10 : startPreset));
    budget = b;
    ackReq();
    chk("R4 high rate after ack", int'(rateHigh), 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reqValid", int'(reqValid), 0);
    chk("R1 rateHigh", int'(rateHigh), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 trained", int'(trained), 0);
    chk("R1 failed", int'(failed), 0);

    // power-up run with coefficient loop
    startPreset = 4'd12;
    pulse(trigPowerUp);
    chk("R2 busy on trigger", int'(busy), 1);
    repeat (4) @(negedge clk);
    chk("R2 no request before align", int'(reqValid), 0);
    bringUp(16'd2000);
    repeat (30) @(negedge clk);
    chk("R4 coarse hold rate", int'(rateHigh), 1);
    chk("R4 coarse no request", int'(reqValid), 0);
    coarseOk = 1'b1;

    for (int i = 0; i < 6; i++) begin
      adjHint = VEC[i][11:10];
      hintPreset = VEC[i][9:6];
      waitReq("R6 coefficient request");
      if (i == 0) chk("R11 early berOk ignored", int'(reqValid), 1);
      chk("R6 kind", int'(reqKind), 2);
      chk("R6 code", int'(reqCode), int'(VEC[i][5:4]));
      chk("R6 preset", int'(reqPreset), int'(VEC[i][3:0]));
      ackReq();
      chk("R7 tune strobe", int'(tuneStart), 1);
      @(negedge clk);
      chk("R7 strobe single", int'(tuneStart), 0);
      repeat (5) @(negedge clk);
      chk("R7 no request while tuning", int'(reqValid), 0);
      @(negedge clk) tuneDone = 1'b1;
      @(negedge clk) begin tuneDone = 1'b0; berOk = 1'b1; end   // first window cycle
      @(negedge clk) berOk = 1'b0;                               // mid-window: ignored (R11)
    end

    waitReq("R11 pulse did not pass window");
    ackReq();
    pulse(tuneDone);
    berOk = 1'b1;
    repeat (20) @(negedge clk);
    chk("R5 no request after pass", int'(reqValid), 0);
    chk("R5 busy in reversal", int'(busy), 1);
    chk("R5 not yet trained", int'(trained), 0);
    pulse(peerDone);
    chk("R5 trained", int'(trained), 1);
    chk("R5 idle", int'(busy), 0);
    chk("R5 rate kept", int'(rateHigh), 1);

    // sync loss from trained restarts; short budget expires
    pulse(trigSyncLoss);
    chk("R9 rate dropped", int'(rateHigh), 0);
    chk("R2 busy after sync loss", int'(busy), 1);
    retryEn = 1'b0;
    bringUp(16'd14);
    repeat (30) @(negedge clk);
    chk("R8 expiry drops rate", int'(rateHigh), 0);
    chk("R10 parked failed", int'(failed), 1);
    chk("R10 not busy", int'(busy), 0);

    // hot-plug from failed; budget ties with the verdict
    pulse(trigHotPlug);
    chk("R10 trigger leaves failed", int'(failed), 0);
    chk("R10 busy again", int'(busy), 1);
    bringUp(16'd15);
    repeat (30) @(negedge clk);
    chk("R8 pass wins tie", int'(rateHigh), 1);
    chk("R8 not failed on tie", int'(failed), 0);
    pulse(peerDone);
    chk("R8 trained after tie", int'(trained), 1);

    // hard reset; sync loss mid-evaluation with retry
    pulse(trigHardReset);
    chk("R2 hard reset trigger", int'(busy), 1);
    berOk = 1'b0;
    retryEn = 1'b1;
    bringUp(16'd1000);
    repeat (3) @(negedge clk);
    pulse(trigSyncLoss);
    chk("R9 sync loss drops rate", int'(rateHigh), 0);
    chk("R10 retry keeps busy", int'(busy), 1);
    chk("R10 retry not failed", int'(failed), 0);
    waitReq("R10 retry setup");
    chk("R10 retry kind", int'(reqKind), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule